// File: doc/BRIEF.md
# Up-Counting Timer with Compare/PWM Channels

This block is a free-running up-counter with a programmable clock divider and a programmable period, feeding a set of compare channels. Each channel turns the count into a reference waveform. The reference can toggle on a compare match, or it can be a pulse-width-modulated level whose period comes from the reload value and whose duty comes from the channel's compare value. Each channel has its own polarity and output-enable control. It also raises a sticky match flag, and a masked interrupt is derived from the flags.

Software programs the block through a small write/read register port. The reload value and each compare value can take effect at once. They can also be held in a shadow register until the counter wraps, so that a period or duty change never produces a truncated or doubled cycle.

Register addresses (4-bit `addr`): 0 control, 1 divider, 2 reload, 3 channel modes, 4 output config, 5 flags, 6 flag mask, 8+i compare value of channel i. Reads return the last written value.

Top module: `pwm_timer`

## Requirements
- R1: The counter advances only while control bit 0 (address 0) is 1. It then steps once every (D+1) clocks, where D is the divider value at address 1. While the bit is 0 the count holds.
- R2: The counter counts 0,1,…,A and wraps to 0, where A is the active reload value. Reset loads A with all ones. The wrap is the update event. A count already above a newly lowered A wraps to 0 on its next step.
- R3: Mode code 3'b110 (channel i's code in bits [4i+2:4i] of address 3) drives the reference active while count < compare, and inactive otherwise. A compare value above A keeps it always active.
- R4: Mode code 3'b111 drives the reference inactive while count < compare, and active otherwise.
- R5: Mode code 3'b011 flips the reference each time the counter steps onto the compare value. The update event alone does not change it.
- R6: Mode code 3'b000 and every other unused code hold the reference at its present level.
- R7: With channel i's buffer bit (bit 4i+3 of address 3) at 0, a compare write takes effect at once. With it at 1, the written value becomes active only at the next update event.
- R8: With control bit 1 at 0, a reload write takes effect at once. With it at 1, the written value becomes active only at the next update event.
- R9: Polarity bit 2i+1 of address 4 at 0 gives an active-high output. At 1 the output is inverted.
- R10: With enable bit 2i of address 4 at 0, `chOe[i]` is 0 and `chOut[i]` is 0. With it at 1, `chOe[i]` is 1 and `chOut[i]` follows the reference after polarity.
- R11: Flag bit i (address 5) sets when the counter steps onto channel i's compare value. Writing 1 to the bit clears it. A match in the same cycle as the clear leaves it set.
- R12: `irq` is 1 exactly when some flag bit is 1 and its mask bit (address 6) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data of the addressed register |
| chOut | output | NCH | Channel outputs after polarity and enable |
| chOe | output | NCH | Channel output enables |
| irq | output | 1 | Masked compare interrupt |

## Verification
The bench goes after the wrap and buffering edges. It shadows a compare value across the first period: a design that copied the value at write time would show the new duty one period early. It buffers a reload change: a design that applied it at once would show seven active cycles of ten instead of ten. It lowers the reload below the running count: a design that only compares for equality would run to the counter's top and show no active cycles. It also clears a flag in the very cycle it is set, where a design that gave the clear priority would lose the match. It checks that toggle mode flips twice per two periods, where a design that also flipped on the update event would show four flips.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic tick;    // counter steps this cycle
    logic update;  // counter wraps to zero this cycle
  } tmrStrobe_t;

  localparam logic [2:0] MODE_FROZEN = 3'b000;
  localparam logic [2:0] MODE_TOGGLE = 3'b011;
  localparam logic [2:0] MODE_PWM1   = 3'b110;
  localparam logic [2:0] MODE_PWM2   = 3'b111;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_PSC    = 1;
  localparam int ADDR_RELOAD = 2;
  localparam int ADDR_MODE   = 3;
  localparam int ADDR_OUTCFG = 4;
  localparam int ADDR_FLAGS  = 5;
  localparam int ADDR_MASK   = 6;
  localparam int ADDR_CMP0   = 8;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [CNT_W-1:0] psc,
  input  logic [CNT_W-1:0] reloadAct,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cntNext,
  output tmrStrobe_t       strb
);
  logic [CNT_W-1:0] psCnt;

  always_comb begin
    strb.tick   = run && (psCnt >= psc);
    // >= so a count stranded above a lowered reload wraps on its next step
    strb.update = strb.tick && (cnt >= reloadAct);
    if (strb.update)    cntNext = '0;
    else if (strb.tick) cntNext = cnt + CNT_W'(1);
    else                cntNext = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
      cnt   <= '0;
    end else begin
      cnt <= cntNext;
      if (!run || strb.tick) psCnt <= '0;
      else                   psCnt <= psCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   cntNext,
  input  tmrStrobe_t         strb,
  output logic [CNT_W-1:0]   rdData,
  output logic               run,
  output logic [CNT_W-1:0]   psc,
  output logic [CNT_W-1:0]   reloadAct,
  output logic [NCH-1:0]     chOut,
  output logic [NCH-1:0]     chOe,
  output logic               irq,
  output logic [NCH-1:0]     flags,
  output logic [NCH*CNT_W-1:0] ccActFlat,
  output logic [NCH*3-1:0]   modeFlat,
  output logic [NCH-1:0]     refFlat
);
  logic             arBuf;
  logic [CNT_W-1:0] arrPre, arrShd;
  logic [NCH-1:0]   enQ, polQ, maskQ, matchVec, cbufV, clrVec;
  logic [2:0]       modeArr  [NCH];
  logic [CNT_W-1:0] ccPreArr [NCH];
  logic [CNT_W-1:0] modeRd, cfgRd;

  function automatic logic hit(input int a);
    return wrEn && (addr == ADDR_W'(a));
  endfunction

  assign reloadAct = arBuf ? arrShd : arrPre;
  assign clrVec    = hit(ADDR_FLAGS) ? wrData[NCH-1:0] : '0;
  assign irq       = |(flags & maskQ);
  assign chOe      = enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run <= 1'b0; arBuf <= 1'b0; psc <= '0;
      arrPre <= '1; arrShd <= '1;
      enQ <= '0; polQ <= '0; maskQ <= '0; flags <= '0;
    end else begin
      if (hit(ADDR_CTRL))   begin run <= wrData[0]; arBuf <= wrData[1]; end
      if (hit(ADDR_PSC))    psc    <= wrData;
      if (hit(ADDR_RELOAD)) arrPre <= wrData;
      if (!arBuf || strb.update) arrShd <= arrPre;
      if (hit(ADDR_MASK))   maskQ  <= wrData[NCH-1:0];
      if (hit(ADDR_OUTCFG))
        for (int i = 0; i < NCH; i++) begin
          enQ[i]  <= wrData[2*i];
          polQ[i] <= wrData[2*i+1];
        end
      flags <= (flags & ~clrVec) | matchVec;  // set wins over clear
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [2:0]       modeR;
    logic             cbufR, refR, refNow, match;
    logic [CNT_W-1:0] ccPreR, ccShdR, ccAct;

    assign ccAct = cbufR ? ccShdR : ccPreR;
    assign match = strb.tick && (cntNext == ccAct);

    always_comb begin
      case (modeR)
        MODE_PWM1: refNow = (cnt < ccAct);
        MODE_PWM2: refNow = !(cnt < ccAct);
        default:   refNow = refR;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeR <= MODE_FROZEN; cbufR <= 1'b0;
        ccPreR <= '0; ccShdR <= '0; refR <= 1'b0;
      end else begin
        if (hit(ADDR_MODE)) begin
          modeR <= wrData[4*i +: 3];
          cbufR <= wrData[4*i+3];
        end
        if (hit(ADDR_CMP0 + i)) ccPreR <= wrData;
        if (!cbufR || strb.update) ccShdR <= ccPreR;
        if (modeR == MODE_TOGGLE && match) refR <= ~refR;
        else                               refR <= refNow;
      end
    end

    assign chOut[i]    = enQ[i] & (refNow ^ polQ[i]);
    assign matchVec[i] = match;
    assign cbufV[i]    = cbufR;
    assign modeArr[i]  = modeR;
    assign ccPreArr[i] = ccPreR;
    assign ccActFlat[i*CNT_W +: CNT_W] = ccAct;
    assign modeFlat[3*i +: 3] = modeR;
    assign refFlat[i] = refR;
  end

  always_comb begin
    modeRd = '0;
    cfgRd  = '0;
    for (int i = 0; i < NCH; i++) begin
      modeRd[4*i +: 4] = {cbufV[i], modeArr[i]};
      cfgRd[2*i +: 2]  = {polQ[i], enQ[i]};
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(ADDR_CTRL):   rdData = CNT_W'({arBuf, run});
      ADDR_W'(ADDR_PSC):    rdData = psc;
      ADDR_W'(ADDR_RELOAD): rdData = arrPre;
      ADDR_W'(ADDR_MODE):   rdData = modeRd;
      ADDR_W'(ADDR_OUTCFG): rdData = cfgRd;
      ADDR_W'(ADDR_FLAGS):  rdData = CNT_W'(flags);
      ADDR_W'(ADDR_MASK):   rdData = CNT_W'(maskQ);
      default:
        for (int i = 0; i < NCH; i++)
          if (addr == ADDR_W'(ADDR_CMP0 + i)) rdData = ccPreArr[i];
    endcase
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NCH-1:0]    chOut,
  output logic [NCH-1:0]    chOe,
  output logic              irq
);
  logic                 run;
  logic [CNT_W-1:0]     psc, reloadAct, cnt, cntNext;
  tmrStrobe_t           strb;
  logic [NCH-1:0]       flags, refFlat;
  logic [NCH*CNT_W-1:0] ccActFlat;
  logic [NCH*3-1:0]     modeFlat;

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .psc(psc), .reloadAct(reloadAct),
    .cnt(cnt), .cntNext(cntNext), .strb(strb)
  );

  tmr_datapath #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cnt(cnt), .cntNext(cntNext), .strb(strb), .rdData(rdData),
    .run(run), .psc(psc), .reloadAct(reloadAct), .chOut(chOut), .chOe(chOe),
    .irq(irq), .flags(flags), .ccActFlat(ccActFlat), .modeFlat(modeFlat),
    .refFlat(refFlat)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 run,
  input logic [CNT_W-1:0]     cnt,
  input logic [CNT_W-1:0]     cntNext,
  input logic                 tick,
  input logic                 update,
  input logic [NCH-1:0]       flags,
  input logic [NCH*CNT_W-1:0] ccActFlat,
  input logic [NCH*3-1:0]     modeFlat,
  input logic [NCH-1:0]       refFlat
);
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(cnt)); // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    update |=> (cnt == '0)); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !update) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      (tick && cntNext == ccActFlat[i*CNT_W +: CNT_W]) |=> flags[i]); // R11
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (modeFlat[3*i +: 3] == 3'b000) |=> $stable(refFlat[i])); // R6
  end
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .run(run), .cnt(cnt), .cntNext(cntNext),
  .tick(strb.tick), .update(strb.update), .flags(flags),
  .ccActFlat(ccActFlat), .modeFlat(modeFlat), .refFlat(refFlat)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;
  localparam int CNT_W = 16;
  localparam int NCH = 2;
  localparam int ADDR_W = 4;
  localparam int A_CTRL = 0, A_PSC = 1, A_RLD = 2, A_MODE = 3,
                 A_CFG = 4, A_FLG = 5, A_MSK = 6, A_CMP0 = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] rdData;
  logic [NCH-1:0] chOut, chOe;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_timer #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chOut(chOut), .chOe(chOe), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = CNT_W'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input int a, output int d);
    @(negedge clk);
    addr = ADDR_W'(a); #1;
    d = int'(rdData);
  endtask

  task automatic countHigh(input int ch, input int n, output int k);
    k = 0;
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      if (chOut[ch]) k++;
    end
  endtask

  task automatic countFlips(input int ch, input int n, output int k);
    logic prev;
    k = 0;
    @(negedge clk); prev = chOut[ch];
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      if (chOut[ch] != prev) k++;
      prev = chOut[ch];
    end
  endtask

  task automatic t_reset();
    int d;
    doReset();
    check(chOut == '0, "R10 reset out", int'(chOut), 0);
    check(chOe == '0, "R10 reset oe", int'(chOe), 0);
    check(irq == 1'b0, "R12 reset irq", int'(irq), 0);
    rdReg(A_FLG, d);  check(d == 0, "R11 reset flags", d, 0);
    rdReg(A_RLD, d);  check(d == 16'hFFFF, "R2 reset reload", d, 16'hFFFF);
  endtask

  task automatic t_stopped();
    int k;
    doReset();
    wrReg(A_RLD, 9); wrReg(A_MODE, 6); wrReg(A_CMP0, 4); wrReg(A_CFG, 1);
    countHigh(0, 20, k);
    check(k == 20, "R1 count held while stopped", k, 20);
  endtask

  task automatic t_pwm();
    int k;
    doReset();
    wrReg(A_RLD, 9); wrReg(A_MODE, 8'h76);
    wrReg(A_CMP0, 4); wrReg(A_CMP0 + 1, 4); wrReg(A_CFG, 5);
    wrReg(A_CTRL, 1);
    countHigh(0, 20, k); check(k == 8, "R3 pwm1 duty", k, 8);
    countHigh(1, 20, k); check(k == 12, "R4 pwm2 duty", k, 12);
    wrReg(A_CMP0, 12);
    countHigh(0, 20, k); check(k == 20, "R3 compare above reload", k, 20);
    wrReg(A_CMP0, 4); wrReg(A_CFG, 7);
    countHigh(0, 20, k); check(k == 12, "R9 inverted polarity", k, 12);
    wrReg(A_CFG, 4);
    countHigh(0, 20, k); check(k == 0, "R10 disabled output", k, 0);
    check(chOe[0] == 1'b0, "R10 disabled oe", int'(chOe[0]), 0);
    check(chOe[1] == 1'b1, "R10 enabled oe", int'(chOe[1]), 1);
  endtask

  task automatic t_prescale();
    int k;
    doReset();
    wrReg(A_PSC, 2); wrReg(A_RLD, 9); wrReg(A_MODE, 6);
    wrReg(A_CMP0, 5); wrReg(A_CFG, 1); wrReg(A_CTRL, 1);
    countHigh(0, 30, k); check(k == 15, "R1 divider by three", k, 15);
  endtask

  task automatic t_toggle();
    int k;
    doReset();
    wrReg(A_RLD, 9); wrReg(A_MODE, 3); wrReg(A_CMP0, 3);
    wrReg(A_CFG, 1); wrReg(A_CTRL, 1);
    countFlips(0, 20, k); check(k == 2, "R5 toggle flips", k, 2);
    wrReg(A_MODE, 0);
    countFlips(0, 20, k); check(k == 0, "R6 frozen holds", k, 0);
    wrReg(A_MODE, 1);
    countFlips(0, 20, k); check(k == 0, "R6 unused code holds", k, 0);
  endtask

  task automatic t_cmpBuf();
    int k;
    doReset();
    wrReg(A_RLD, 9); wrReg(A_MODE, 8'hE); wrReg(A_CMP0, 4); wrReg(A_CFG, 1);
    wrReg(A_CTRL, 1);
    countHigh(0, 10, k); check(k == 0, "R7 buffered first period", k, 0);
    countHigh(0, 10, k); check(k == 4, "R7 buffered after update", k, 4);
    doReset();
    wrReg(A_RLD, 9); wrReg(A_MODE, 6); wrReg(A_CMP0, 4); wrReg(A_CFG, 1);
    wrReg(A_CTRL, 1);
    countHigh(0, 10, k); check(k == 4, "R7 direct first period", k, 4);
  endtask

  task automatic t_rldBuf();
    int k;
    doReset();
    wrReg(A_RLD, 4); wrReg(A_CTRL, 2); wrReg(A_RLD, 9);
    wrReg(A_MODE, 6); wrReg(A_CMP0, 7); wrReg(A_CFG, 1);
    wrReg(A_CTRL, 3);
    countHigh(0, 10, k); check(k == 10, "R8 old reload until update", k, 10);
    countHigh(0, 10, k); check(k == 7, "R8 new reload after update", k, 7);
  endtask

  task automatic t_lower();
    int k;
    doReset();
    wrReg(A_RLD, 9); wrReg(A_MODE, 6); wrReg(A_CMP0, 2); wrReg(A_CFG, 1);
    wrReg(A_CTRL, 1);
    repeat (6) @(posedge clk);
    wrReg(A_RLD, 3);
    countHigh(0, 9, k); check(k == 4, "R2 wrap above lowered reload", k, 4);
  endtask

  task automatic t_flags();
    int d;
    doReset();
    wrReg(A_RLD, 9); wrReg(A_MODE, 3); wrReg(A_CMP0, 3);
    wrReg(A_CTRL, 1);
    repeat (12) @(posedge clk);
    wrReg(A_FLG, 1);  // clear lands on the match cycle
    rdReg(A_FLG, d);
    check((d & 1) == 1, "R11 set wins over clear", d & 1, 1);
    check(irq == 1'b0, "R12 masked off", int'(irq), 0);
    wrReg(A_MSK, 1);
    check(irq == 1'b1, "R12 mask on", int'(irq), 1);
    wrReg(A_FLG, 1);
    check(irq == 1'b0, "R12 after clear", int'(irq), 0);
    rdReg(A_FLG, d);
    check((d & 1) == 0, "R11 write one clears", d & 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stopped();
    t_pwm();
    t_prescale();
    t_toggle();
    t_cmpBuf();
    t_rldBuf();
    t_lower();
    t_flags();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule